// File: doc/BRIEF.md
# Barrel Shifter with Carry Flag

This block is a purely combinational word shifter for a processor datapath. It takes a data word, a three-bit shift kind, a shift count and the current carry flag. In the same cycle it returns the shifted word and the carry value that a flag-setting instruction would store. Five kinds are provided: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag.

The count input is a full register-width word, so one datapath serves two uses. A small immediate count is zero-extended onto it, and a count read from a register is fed in directly. Only the low byte of the count matters.

Zero, exactly the word width, and anything above the word width each have their own carry rule. Because those cases are where flag bugs usually hide, they are fixed by the requirements below. Nothing is registered. The consumer (an ALU stage or a flag register) decides what to keep.

Top module: `barrel_carry_shifter`

## Requirements
- R1: Only bits [7:0] of `shift_amt` take effect. Two counts with the same low byte give identical `result_word` and `carry_out` for every other input.
- R2: For kinds 0, 1, 2 and 3 (logical left, logical right, arithmetic right, rotate right) with an effective count of 0, `result_word` equals `src_word` and `carry_out` equals `carry_in`.
- R3: Kind 0 (logical left) with count n in 1..31 gives `src_word << n` with zeros entering from bit 0. `carry_out` is `src_word[32-n]`, the last bit pushed out.
- R4: Kind 0 at count 32 gives a zero word with `carry_out` = `src_word[0]`. At counts 33..255 it gives a zero word with `carry_out` = 0.
- R5: Kind 1 (logical right) with count n in 1..31 gives `src_word >> n` with `carry_out` = `src_word[n-1]`. At 32 the word is zero and `carry_out` = `src_word[31]`. At 33..255 both the word and the carry are zero.
- R6: Kind 2 (arithmetic right) with count n in 1..31 fills the vacated top bits with `src_word[31]`, and `carry_out` = `src_word[n-1]`. At any count of 32 or more, every result bit and `carry_out` equal `src_word[31]`.
- R7: Kind 3 (rotate right) with a nonzero count rotates by the count modulo 32, and `carry_out` equals bit 31 of the rotated word. A nonzero multiple of 32 therefore returns `src_word` with `carry_out` = `src_word[31]`.
- R8: Kind 4 (rotate through carry) ignores the count. It returns `{carry_in, src_word[31:1]}` with `carry_out` = `src_word[0]`.
- R9: Kind codes 5, 6 and 7 are reserved. They pass `src_word` through unchanged with `carry_out` = `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Data word to shift |
| shift_kind | input | 3 | 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right, 4 rotate through carry |
| shift_amt | input | 32 | Shift count; only the low byte is used |
| carry_in | input | 1 | Current carry flag |
| result_word | output | 32 | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The block holds no state. A fault in any selection path therefore shows on the ports in the same evaluation as the input that selects it, and the result or carry is wrong immediately. The faults most likely to hide are those confined to one count band: 0, 32, 33 and above, and the multiple-of-32 rotate. A wrong carry there leaves the data word correct and differs in a single bit. For that reason each kind is driven at every band edge, as well as with random data and counts whose upper bits are deliberately noisy.

// File: rtl/barrel_carry_shifter.sv
module barrel_carry_shifter #(
  parameter int WIDTH      = 32,
  parameter int AMT_IN_W   = 32,
  parameter int AMT_USED_W = 8
) (
  input  logic [WIDTH-1:0]    src_word,
  input  logic [2:0]          shift_kind,
  input  logic [AMT_IN_W-1:0] shift_amt,
  input  logic                carry_in,
  output logic [WIDTH-1:0]    result_word,
  output logic                carry_out
);
  localparam int ROT_W = $clog2(WIDTH);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;
  localparam logic [AMT_USED_W-1:0] AMT_FULL = AMT_USED_W'(WIDTH);

  logic [AMT_USED_W-1:0] amt;
  logic                  unused_amt_hi;
  logic                  zero_amt;
  logic [AMT_USED_W-1:0] asr_amt;
  logic [ROT_W-1:0]      rot;
  logic [WIDTH:0]        lsl_ext;
  logic [WIDTH:0]        lsr_ext;
  logic signed [WIDTH:0] asr_ext;
  logic [WIDTH-1:0]      ror_res;

  assign amt           = shift_amt[AMT_USED_W-1:0];
  assign unused_amt_hi = ^shift_amt[AMT_IN_W-1:AMT_USED_W];
  assign zero_amt      = (amt == '0);

  // Extra bit on the far side of each shift catches the last bit pushed out.
  assign lsl_ext = {1'b0, src_word} << amt;
  assign lsr_ext = {src_word, 1'b0} >> amt;
  assign asr_amt = (amt > AMT_FULL) ? AMT_FULL : amt;
  assign asr_ext = $signed({src_word, 1'b0}) >>> asr_amt;
  assign rot     = amt[ROT_W-1:0];
  assign ror_res = (src_word >> rot) | (src_word << (WIDTH - int'(rot)));

  always_comb begin
    result_word = src_word;
    carry_out   = carry_in;
    unique case (shift_kind)
      K_LSL: if (!zero_amt) {carry_out, result_word} = lsl_ext;
      K_LSR: if (!zero_amt) {result_word, carry_out} = lsr_ext;
      K_ASR: if (!zero_amt) {result_word, carry_out} = asr_ext;
      K_ROR: if (!zero_amt) begin
        result_word = ror_res;
        carry_out   = ror_res[WIDTH-1];
      end
      K_RRX: begin
        result_word = {carry_in, src_word[WIDTH-1:1]};
        carry_out   = src_word[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/barrel_carry_shifter_chk.sv
module barrel_carry_shifter_chk #(
  parameter int WIDTH      = 32,
  parameter int AMT_IN_W   = 32,
  parameter int AMT_USED_W = 8
) (
  input logic [WIDTH-1:0]    src_word,
  input logic [2:0]          shift_kind,
  input logic [AMT_IN_W-1:0] shift_amt,
  input logic                carry_in,
  input logic [WIDTH-1:0]    result_word,
  input logic                carry_out
);
  logic [AMT_USED_W-1:0] a;
  logic                  known;
  assign a     = shift_amt[AMT_USED_W-1:0];
  assign known = !$isunknown({src_word, shift_kind, shift_amt, carry_in});

  always_comb begin
    if (known) begin
      if (shift_kind <= 3'd3 && a == '0)
        assert_zero_pass_R2: assert (result_word == src_word && carry_out == carry_in);
      if (shift_kind == 3'd0 && a != '0 && a < AMT_USED_W'(WIDTH))
        assert_lsl_fill_R3: assert (result_word[0] == 1'b0);
      if (shift_kind == 3'd0 && a > AMT_USED_W'(WIDTH))
        assert_lsl_over_R4: assert (result_word == '0 && carry_out == 1'b0);
      if (shift_kind == 3'd1 && a == AMT_USED_W'(WIDTH))
        assert_lsr_full_R5: assert (result_word == '0 && carry_out == src_word[WIDTH-1]);
      if (shift_kind == 3'd2 && a >= AMT_USED_W'(WIDTH))
        assert_asr_sat_R6: assert (result_word == {WIDTH{src_word[WIDTH-1]}} && carry_out == src_word[WIDTH-1]);
      if (shift_kind == 3'd3 && a != '0)
        assert_ror_carry_R7: assert (carry_out == result_word[WIDTH-1]);
      if (shift_kind == 3'd4)
        assert_rrx_R8: assert (result_word[WIDTH-1] == carry_in && carry_out == src_word[0]);
      if (shift_kind > 3'd4)
        assert_reserved_R9: assert (result_word == src_word && carry_out == carry_in);
    end
  end
endmodule

bind barrel_carry_shifter barrel_carry_shifter_chk #(
  .WIDTH(WIDTH), .AMT_IN_W(AMT_IN_W), .AMT_USED_W(AMT_USED_W)
) u_chk (
  .src_word(src_word), .shift_kind(shift_kind), .shift_amt(shift_amt),
  .carry_in(carry_in), .result_word(result_word), .carry_out(carry_out)
);

// File: tb/barrel_carry_shifter_test.sv
module barrel_carry_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic [31:0] src_word;
  logic [2:0]  shift_kind;
  logic [31:0] shift_amt;
  logic        carry_in;
  logic [31:0] result_word;
  logic        carry_out;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_carry_shifter uut (
    .src_word(src_word), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .carry_in(carry_in), .result_word(result_word), .carry_out(carry_out)
  );

  // Bit-by-bit model built from the requirement text.
  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] d,
                                        input logic [31:0] amt32, input logic ci);
    int n = int'(amt32[7:0]);
    logic [31:0] r = d;
    logic c = ci;
    if (k == 3'd4) begin
      r = {ci, d[31:1]}; c = d[0];
    end else if (k <= 3'd3 && n != 0) begin
      case (k)
        3'd0: begin
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? d[i-n] : 1'b0;
          c = (n <= 32) ? d[32-n] : 1'b0;
        end
        3'd1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i+n] : 1'b0;
          c = (n <= 32) ? d[n-1] : 1'b0;
        end
        3'd2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? d[i+n] : d[31];
          c = (n <= 32) ? d[n-1] : d[31];
        end
        default: begin
          for (int i = 0; i < 32; i++) r[i] = d[(i + n) % 32];
          c = r[31];
        end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string req_tag(input logic [2:0] k, input logic [31:0] amt32);
    int n = int'(amt32[7:0]);
    if (k > 3'd4) return "R9";
    if (k == 3'd4) return "R8";
    if (n == 0) return "R2";
    case (k)
      3'd0: return (n < 32) ? "R3" : "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] k, input logic [31:0] d,
                       input logic [31:0] amt32, input logic ci, input string tag);
    logic [32:0] exp;
    src_word = d; shift_kind = k; shift_amt = amt32; carry_in = ci;
    #(CLK_PERIOD/2);
    exp = model(k, d, amt32, ci);
    checks++;
    if ({carry_out, result_word} !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d amt=%h data=%h cin=%b: got %h/%b expected %h/%b",
               tag, k, amt32, d, ci, result_word, carry_out, exp[31:0], exp[32]);
    end
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int amts[8] = '{0, 1, 31, 32, 33, 64, 200, 255};
    logic [31:0] pats[3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96};
    void'($urandom(32'd1234));
    // Quiet starting point.
    apply(3'd0, 32'h0, 32'h0, 1'b0, "R2");
    // Directed band edges for every kind, both carry values.
    for (int k = 0; k < 8; k++)
      for (int ai = 0; ai < 8; ai++)
        for (int p = 0; p < 3; p++)
          for (int ci = 0; ci < 2; ci++)
            apply(3'(k), pats[p], 32'(amts[ai]), 1'(ci), req_tag(3'(k), 32'(amts[ai])));
    // R1: noisy upper count bits must not matter.
    for (int k = 0; k < 5; k++)
      for (int ai = 0; ai < 8; ai++)
        apply(3'(k), 32'hC001_D00D, {24'hF3A5_17, 8'(amts[ai])}, 1'b1, "R1");
    // Random data, counts and kinds.
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  k  = 3'($urandom_range(0, 7));
      logic [31:0] am = $urandom();
      apply(k, $urandom(), am, 1'($urandom()), (am[31:8] != 0) ? "R1" : req_tag(k, am));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule